// File: doc/BRIEF.md
# Block-Transfer I2C Register Slave

This block is an I2C slave for standard-mode buses (100 kbit/s or slower, 8-bit bytes). It gives access to a file of 21 configuration bytes and only ever moves data as whole blocks. A write transfer starts at register 0. A read transfer always returns a length byte first and then registers from 0 upward. The SCL and SDA pins are oversampled by the block's own clock through two-flop synchronizers. The slave drives SDA only through an open-drain enable, and the live register contents are presented in parallel to the surrounding logic.

A write sends the device write address, then a command byte and a count byte. The slave acknowledges both and discards their values. Data bytes follow and land in registers 0, 1, 2 and onward. The master may stop after any complete byte. Two register pairs, 11/12 and 13/14, are committed together only when the second byte of the pair arrives. A lone first byte never reaches the live file. Register 8 sets how many register bytes a read returns. Register 7 is a fixed identity byte.

Top module: `blkreg_i2c_slave`

## Requirements
- R1: The slave acknowledges the address byte 0xD2 (write) and 0xD3 (read). Any other address byte is not acknowledged, and SDA stays released until the next start condition.
- R2: In a write, the first two bytes after the address are acknowledged, and their values change no register.
- R3: In a write, data byte k (k = 0, 1, ...) is acknowledged and goes to register k. Bytes beyond register 20 are acknowledged and discarded. A stop after any complete byte keeps the bytes written before it.
- R4: A read returns the value of register 8 as its first byte, followed by register 0, register 1 and so on.
- R5: After the length byte, a read returns min(register 8, 21) register bytes. Every byte clocked out after those reads as 0xFF, because SDA is released.
- R6: Register 8 resets to 0x08. A write of 0x00 to register 8 is ignored.
- R7: Registers 11 and 12 change only together, when the byte for register 12 is received. The same holds for registers 13 and 14 when the byte for register 14 is received. A transfer that ends after the first byte of a pair leaves both registers of the pair unchanged.
- R8: Register 7 reads {VENDOR_ID, REVISION} (defaults 0x35), and writes to it are ignored.
- R9: When the master does not acknowledge a read byte, the slave stops driving data and keeps SDA released until the next start or stop.
- R10: A start or a stop condition abandons a partly received byte, which is never stored. A repeated start begins a new address phase.
- R11: After reset, every register reads 0x00 except registers 7 and 8, and SDA is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling system clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | I2C clock line, asynchronous |
| sda_in | input | 1 | I2C data line, asynchronous |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| cfg_regs | output | 168 | Live register file, register i in bits [8i+7:8i] |

## Verification
Two functions can act in the same data phase: the pair commit rule and the read-length limit. The commit for the second byte of a pair fires on the same SCL edge that acknowledges it. A read whose length has just been rewritten must then return a pair that is either wholly old or wholly new. The bench provokes this by mixing random writes of random length, which stop inside and after the pairs and sometimes write 0x00 or large values to register 8, with reads of random length. Every returned byte is judged against a model built from the requirements.

// File: rtl/blkreg_pkg.sv
package blkreg_pkg;

    localparam int NREG  = 21;
    localparam int IDX_W = 5;
    localparam int CNT_W = 6;

    localparam logic [IDX_W-1:0] IDX_ID    = 5'd7;
    localparam logic [IDX_W-1:0] IDX_CNT   = 5'd8;
    localparam logic [IDX_W-1:0] IDX_PA_LO = 5'd11;
    localparam logic [IDX_W-1:0] IDX_PA_HI = 5'd12;
    localparam logic [IDX_W-1:0] IDX_PB_LO = 5'd13;
    localparam logic [IDX_W-1:0] IDX_PB_HI = 5'd14;
    localparam logic [IDX_W-1:0] NREG_IDX  = IDX_W'(NREG);

    localparam logic [7:0] CNT_RESET = 8'h08;
    localparam logic [6:0] DEV_ADDR  = 7'h69;

    typedef logic [NREG*8-1:0] cfg_vec_t;

    typedef enum logic [2:0] {
        L_IDLE, L_ADDR, L_AACK, L_WBYTE, L_WACK, L_RBYTE, L_RACK, L_IGNORE
    } link_st_e;

    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] idx;
        logic [7:0]       data;
    } reg_wr_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    function automatic logic [7:0] cfg_byte(cfg_vec_t v, logic [IDX_W-1:0] i);
        return v[int'(i)*8 +: 8];
    endfunction

    function automatic logic [IDX_W-1:0] rd_limit(logic [7:0] cnt);
        return (cnt > 8'(NREG)) ? NREG_IDX : cnt[IDX_W-1:0];
    endfunction

endpackage

// File: rtl/blkreg_busmon.sv
module blkreg_busmon
    import blkreg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);
    logic [SYNC_STAGES-1:0] scl_sr, sda_sr;
    logic scl_q, sda_q, scl_s, sda_s;

    assign scl_s = scl_sr[SYNC_STAGES-1];
    assign sda_s = sda_sr[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sr <= '1;
            sda_sr <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sr <= {scl_sr[SYNC_STAGES-2:0], scl_in};
            sda_sr <= {sda_sr[SYNC_STAGES-2:0], sda_in};
            scl_q  <= scl_s;
            sda_q  <= sda_s;
        end
    end

    // SDA edges while SCL stays high are bus conditions
    always_comb begin
        ev.start = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop  = scl_s & scl_q & ~sda_q & sda_s;
        ev.rise  = scl_s & ~scl_q;
        ev.fall  = ~scl_s & scl_q;
        ev.sda   = sda_s;
    end
endmodule

// File: rtl/blkreg_file.sv
module blkreg_file
    import blkreg_pkg::*;
#(
    parameter logic [3:0] VENDOR_ID = 4'h3,
    parameter logic [3:0] REVISION  = 4'h5
) (
    input  logic     clk,
    input  logic     rst,
    input  reg_wr_t  wr,
    output cfg_vec_t regs
);
    localparam logic [7:0] ID_BYTE = {VENDOR_ID, REVISION};

    logic [7:0] live [NREG];
    logic [7:0] sh_a, sh_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) live[i] <= 8'h00;
            live[IDX_ID]  <= ID_BYTE;
            live[IDX_CNT] <= CNT_RESET;
            sh_a <= 8'h00;
            sh_b <= 8'h00;
        end else if (wr.en) begin
            case (wr.idx)
                IDX_ID:    ;
                IDX_CNT:   if (wr.data != 8'h00) live[IDX_CNT] <= wr.data;
                IDX_PA_LO: sh_a <= wr.data;
                IDX_PA_HI: begin
                    live[IDX_PA_LO] <= sh_a;
                    live[IDX_PA_HI] <= wr.data;
                end
                IDX_PB_LO: sh_b <= wr.data;
                IDX_PB_HI: begin
                    live[IDX_PB_LO] <= sh_b;
                    live[IDX_PB_HI] <= wr.data;
                end
                default:   if (wr.idx < NREG_IDX) live[wr.idx] <= wr.data;
            endcase
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_flat
        assign regs[g*8 +: 8] = live[g];
    end

    AST_ID_FIXED: assert property (@(posedge clk) disable iff (rst)
        $stable(live[IDX_ID])) else $error("id byte changed"); // R8
    AST_CNT_NONZERO: assert property (@(posedge clk) disable iff (rst)
        live[IDX_CNT] != 8'h00) else $error("length register zero"); // R6
    AST_PAIR_A: assert property (@(posedge clk) disable iff (rst)
        (live[IDX_PA_LO] != $past(live[IDX_PA_LO])) |-> $past(wr.en && wr.idx == IDX_PA_HI))
        else $error("pair A low byte moved alone"); // R7
    AST_PAIR_B: assert property (@(posedge clk) disable iff (rst)
        (live[IDX_PB_LO] != $past(live[IDX_PB_LO])) |-> $past(wr.en && wr.idx == IDX_PB_HI))
        else $error("pair B low byte moved alone"); // R7
endmodule

// File: rtl/blkreg_link.sv
module blkreg_link
    import blkreg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_ev_t  ev,
    input  cfg_vec_t regs,
    output reg_wr_t  wr,
    output logic     sda_oe
);
    link_st_e         st;
    logic [3:0]       bitcnt;
    logic [7:0]       rx, tx;
    logic             rd_dir, mack;
    logic [CNT_W-1:0] wcnt;
    logic [IDX_W-1:0] ridx;
    logic             byte_done;

    assign byte_done = ev.fall && bitcnt == 4'd8;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= L_IDLE; bitcnt <= '0; rx <= '0; tx <= '1;
            rd_dir <= 1'b0; mack <= 1'b0; wcnt <= '0; ridx <= '0;
        end else if (ev.start) begin
            st <= L_ADDR;
            bitcnt <= '0;
        end else if (ev.stop) begin
            st <= L_IDLE;
        end else begin
            case (st)
                L_ADDR, L_WBYTE: begin
                    if (ev.rise) begin
                        rx <= {rx[6:0], ev.sda};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (byte_done) begin
                        if (st == L_WBYTE) begin
                            st <= L_WACK;
                            if (wcnt != '1) wcnt <= wcnt + 1'b1;
                        end else if (rx[7:1] == DEV_ADDR) begin
                            st <= L_AACK;
                            rd_dir <= rx[0];
                        end else begin
                            st <= L_IGNORE;
                        end
                    end
                end
                L_AACK: if (ev.fall) begin
                    bitcnt <= '0;
                    if (rd_dir) begin
                        st <= L_RBYTE;
                        tx <= cfg_byte(regs, IDX_CNT);
                        ridx <= '0;
                    end else begin
                        st <= L_WBYTE;
                        wcnt <= '0;
                    end
                end
                L_WACK: if (ev.fall) begin
                    st <= L_WBYTE;
                    bitcnt <= '0;
                end
                L_RBYTE: begin
                    if (ev.rise) bitcnt <= bitcnt + 4'd1;
                    else if (byte_done) st <= L_RACK;
                    else if (ev.fall) tx <= {tx[6:0], 1'b1};
                end
                L_RACK: begin
                    if (ev.rise) mack <= ~ev.sda;
                    else if (ev.fall) begin
                        if (mack) begin
                            st <= L_RBYTE;
                            bitcnt <= '0;
                            tx <= (ridx < rd_limit(cfg_byte(regs, IDX_CNT)))
                                  ? cfg_byte(regs, ridx) : 8'hFF;
                            if (ridx != '1) ridx <= ridx + 1'b1;
                        end else begin
                            st <= L_IGNORE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // data byte k is the (k+2)-th byte after the address
    always_comb begin
        wr.en   = (st == L_WBYTE) && byte_done && !ev.start && !ev.stop
                  && wcnt >= CNT_W'(2) && wcnt < CNT_W'(NREG + 2);
        wr.idx  = IDX_W'(wcnt - CNT_W'(2));
        wr.data = rx;
    end

    assign sda_oe = (st == L_AACK) || (st == L_WACK) || (st == L_RBYTE && !tx[7]);

    AST_WR_ACKED: assert property (@(posedge clk) disable iff (rst)
        wr.en |=> sda_oe) else $error("stored byte not acknowledged"); // R3
    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> !sda_oe) else $error("SDA held after stop"); // R9
    AST_START_RELEASE: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> !sda_oe) else $error("SDA held after start"); // R10
    AST_NO_WR_ON_READ: assert property (@(posedge clk) disable iff (rst)
        rd_dir && st == L_RBYTE |-> !wr.en) else $error("write during read"); // R4
endmodule

// File: rtl/blkreg_i2c_slave.sv
module blkreg_i2c_slave
    import blkreg_pkg::*;
#(
    parameter logic [3:0] VENDOR_ID   = 4'h3,
    parameter logic [3:0] REVISION    = 4'h5,
    parameter int         SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               sda_oe,
    output logic [NREG*8-1:0]  cfg_regs
);
    bus_ev_t  ev;
    reg_wr_t  wr;
    cfg_vec_t regs;

    blkreg_busmon #(.SYNC_STAGES(SYNC_STAGES)) u_busmon (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in), .ev(ev)
    );

    blkreg_link u_link (
        .clk(clk), .rst(rst), .ev(ev), .regs(regs), .wr(wr), .sda_oe(sda_oe)
    );

    blkreg_file #(.VENDOR_ID(VENDOR_ID), .REVISION(REVISION)) u_file (
        .clk(clk), .rst(rst), .wr(wr), .regs(regs)
    );

    assign cfg_regs = regs;
endmodule

// File: tb/blkreg_i2c_slave_bench.sv
module blkreg_i2c_slave_bench;
    localparam int Q  = 6;
    localparam int WD = 200000;
    localparam logic [7:0] ID = 8'h35;

    logic clk = 1'b0, rst = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_oe, sda_bus;
    logic [167:0] cfg_regs;
    int checks = 0, failures = 0;
    logic [7:0] m [21];
    logic [7:0] sh11, sh13;
    logic [7:0] wbuf [32];

    always #2.5 clk = ~clk;
    assign sda_bus = sda_m & ~sda_oe;

    blkreg_i2c_slave u_blkreg_i2c_slave (
        .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_bus),
        .sda_oe(sda_oe), .cfg_regs(cfg_regs)
    );

    task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic qtr(); repeat (Q) @(negedge clk); endtask

    task automatic i2c_start();
        sda_m = 1'b1; qtr(); scl_m = 1'b1; qtr(); sda_m = 1'b0; qtr(); scl_m = 1'b0; qtr();
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; qtr(); scl_m = 1'b1; qtr(); sda_m = 1'b1; qtr();
    endtask

    task automatic send_bits(logic [7:0] b, int n);
        for (int i = 0; i < n; i++) begin
            sda_m = b[7-i]; qtr(); scl_m = 1'b1; qtr(); qtr(); scl_m = 1'b0; qtr();
        end
    endtask

    task automatic send_byte(logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_m = 1'b1; qtr(); scl_m = 1'b1; qtr();
        ack = ~sda_bus;
        qtr(); scl_m = 1'b0; qtr();
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic ack);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            qtr(); scl_m = 1'b1; qtr(); b[i] = sda_bus; qtr(); scl_m = 1'b0;
        end
        qtr(); sda_m = ~ack; qtr(); scl_m = 1'b1; qtr(); qtr(); scl_m = 1'b0; qtr();
        sda_m = 1'b1;
    endtask

    // model of one stored data byte, from R3 R6 R7 R8
    task automatic mdl_wr(int idx, logic [7:0] d);
        if (idx == 7 || idx > 20) return;
        if (idx == 8) begin if (d != 8'h00) m[8] = d; return; end
        if (idx == 11) begin sh11 = d; return; end
        if (idx == 13) begin sh13 = d; return; end
        if (idx == 12) m[11] = sh11;
        if (idx == 14) m[13] = sh13;
        m[idx] = d;
    endtask

    task automatic wr_xfer(int n, bit do_stop);
        logic a;
        i2c_start();
        send_byte(8'hD2, a); chk("R1 write address ack", 8'(a), 8'h01);
        send_byte(8'($urandom), a); chk("R2 command byte ack", 8'(a), 8'h01);
        send_byte(8'($urandom), a); chk("R2 count byte ack", 8'(a), 8'h01);
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], a);
            chk("R3 data byte ack", 8'(a), 8'h01);
            mdl_wr(i, wbuf[i]);
        end
        if (do_stop) i2c_stop();
    endtask

    task automatic rd_xfer(int n);
        logic a;
        logic [7:0] b;
        int lim;
        i2c_start();
        send_byte(8'hD3, a); chk("R1 read address ack", 8'(a), 8'h01);
        recv_byte(b, n > 0); chk("R4 length byte", b, m[8]);
        lim = (m[8] > 21) ? 21 : int'(m[8]);
        for (int i = 0; i < n; i++) begin
            recv_byte(b, i < n - 1);
            if (i < lim) chk("R4 R5 register byte", b, m[i]);
            else         chk("R5 past limit reads FF", b, 8'hFF);
        end
        i2c_stop();
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        failures++;
        $display("FAIL watchdog got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic a;
        logic [7:0] b;
        void'($urandom(32'h1C5E_ED01));
        for (int i = 0; i < 21; i++) m[i] = 8'h00;
        m[7] = ID; m[8] = 8'h08; sh11 = 8'h00; sh13 = 8'h00;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R11 reset state
        chk("R11 SDA released after reset", 8'(sda_oe), 8'h00);
        chk("R11 reg0 after reset", cfg_regs[7:0], 8'h00);
        chk("R6 R11 reg8 after reset", cfg_regs[71:64], 8'h08);
        chk("R8 R11 reg7 after reset", cfg_regs[63:56], ID);
        rd_xfer(10);

        // R1 foreign address: no ack, then silent
        i2c_start();
        send_byte(8'hA0, a); chk("R1 foreign address nack", 8'(a), 8'h00);
        send_byte(8'h00, a); chk("R1 silent after foreign address", 8'(a), 8'h00);
        i2c_stop();

        // R3 R8 write regs 0..8 incl. reg7 attempt, length 0x19
        for (int i = 0; i < 9; i++) wbuf[i] = 8'h10 + 8'(i);
        wbuf[7] = 8'hAA; wbuf[8] = 8'h19;
        wr_xfer(9, 1);
        chk("R8 reg7 unchanged by write", cfg_regs[63:56], ID);
        chk("R3 reg3 written", cfg_regs[31:24], 8'h13);
        rd_xfer(23);

        // R6 zero to length register ignored
        wbuf[8] = 8'h00;
        wr_xfer(9, 1);
        chk("R6 zero write to reg8 ignored", cfg_regs[71:64], 8'h19);

        // R7 partial pair, then complete pair, then partial second pair
        for (int i = 0; i < 23; i++) wbuf[i] = 8'h40 + 8'(i);
        wbuf[8] = 8'h19;
        wr_xfer(12, 1);
        chk("R7 lone reg11 not committed", cfg_regs[95:88], 8'h00);
        wr_xfer(14, 1);
        chk("R7 reg11 committed with reg12", cfg_regs[95:88], 8'h4B);
        chk("R7 reg13 lone not committed", cfg_regs[111:104], 8'h00);
        wbuf[11] = 8'h77; wbuf[12] = 8'h78;
        wr_xfer(23, 1);
        chk("R7 reg14 with pair", cfg_regs[119:112], 8'h4E);
        chk("R3 reg20 written", cfg_regs[167:160], 8'h54);
        rd_xfer(21);

        // R10 stop inside a data byte
        wbuf[0] = 8'h5A;
        wr_xfer(1, 0);
        send_bits(8'h33, 4);
        i2c_stop();
        chk("R10 reg0 full byte kept", cfg_regs[7:0], 8'h5A);
        chk("R10 reg1 partial byte dropped", cfg_regs[15:8], m[1]);

        // R10 repeated start inside address, then write, then repeated start into read
        i2c_start();
        send_bits(8'hD2, 5);
        wbuf[0] = 8'hC3;
        wr_xfer(1, 0);
        chk("R10 write after repeated start", cfg_regs[7:0], 8'hC3);
        rd_xfer(3);

        // R9 master nack ends data
        i2c_start();
        send_byte(8'hD3, a); chk("R1 read address ack", 8'(a), 8'h01);
        recv_byte(b, 1'b1); chk("R4 length byte", b, m[8]);
        recv_byte(b, 1'b0); chk("R4 reg0 before nack", b, m[0]);
        recv_byte(b, 1'b1); chk("R9 released after nack", b, 8'hFF);
        i2c_stop();

        // random mix
        for (int it = 0; it < 12; it++) begin
            int n;
            n = $urandom_range(1, 23);
            for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
            if (n > 8) wbuf[8] = 8'($urandom_range(0, 30));
            wr_xfer(n, 1);
            rd_xfer($urandom_range(0, 24));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule